// File: doc/BRIEF.md
# ECC Error Status and Interrupt Controller

This block collects error events from the checking logic of a four-bank, ECC-protected on-chip RAM and turns them into software-visible sticky flags and one interrupt line. Each bank can report four kinds of event as one-cycle pulses: a corrected single-bit error, an uncorrectable multi-bit error, a write-strobe error and an access error. That gives sixteen flags.

Two masks control the flags. The record mask decides whether an event may set its flag at all. The signal mask decides which set flags drive the interrupt. A global checking switch suppresses all recording while it is off. Software reads and writes four word registers through a plain register port. It clears flags by writing ones to the flag register, and it changes the masks by read-modify-write.

The register port has no back-pressure. A write is taken on every clock edge where the write strobe is high. Read data is a combinational function of the address in the same cycle. The event inputs are plain pulses with no handshake.

Top module: `ecc_err_ctrl`

## Requirements
- R1: After reset the control word, flag word, record mask and signal mask all read 0, and `irq` is 0.
- R2: Flag bit index = class*4 + bank, where class 0 is single-bit, 1 is multi-bit, 2 is strobe and 3 is access. The same layout is used by the flag word, the record mask and the signal mask.
- R3: An event pulse sets its flag on the next clock edge only when its record-mask bit is 1 and checking is on. Once set, a flag stays set until software clears it.
- R4: While the checking bit (control word bit 0) is 0, no flag becomes set, and flags already set keep their values.
- R5: Writing the flag word (word address 1) clears each flag whose data bit is 1. Flags whose data bit is 0 keep their values, so writing 0x0000FFFF clears all sixteen.
- R6: If a recordable event and a clearing write hit the same flag in the same cycle, the flag stays set.
- R7: `irq` is a register. In each cycle it equals the OR, taken in the previous cycle, of all flags that are set and have their signal-mask bit at 1. It therefore drops one cycle after the last enabled flag is cleared.
- R8: The signal mask does not affect recording: a flag is set even when its signal-mask bit is 0.
- R9: Word addresses are 0 for control, 1 for flags, 2 for the record mask and 3 for the signal mask. The masks are read/write. Bits above 15 of the mask and flag words, and above 0 of the control word, read 0 and ignore writes. Addresses 4 to 7 read 0 and ignore writes.
- R10: `bus_rdata` shows the addressed register in the same cycle that `bus_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_single | input | 4 | Per-bank corrected single-bit error pulse |
| ev_multi | input | 4 | Per-bank uncorrectable multi-bit error pulse |
| ev_strobe | input | 4 | Per-bank write-strobe error pulse |
| ev_access | input | 4 | Per-bank access error pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq | output | 1 | Combined error interrupt |

## Verification
The hardest case to reach from the ports is a collision: an event and a clearing write that land on the same flag in the same cycle. The bench sets up that collision deliberately, with the write and the pulse driven together in one cycle. It then reads the flag back to show the set wins over the clear. The other delicate point is timing of the interrupt. Across mask writes and flag clears, a per-cycle reference model checks that `irq` follows the enabled flags exactly one cycle late. A long random phase then mixes event pulses with writes to every address, including the unmapped ones and the control word, so that the masks and the checking switch keep changing while events arrive.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

  localparam int NCLASS = 4;

  typedef enum logic [1:0] {
    CLS_SINGLE = 2'd0,
    CLS_MULTI  = 2'd1,
    CLS_STROBE = 2'd2,
    CLS_ACCESS = 2'd3
  } err_class_e;

  localparam int REG_CTRL   = 0;
  localparam int REG_FLAGS  = 1;
  localparam int REG_RECMSK = 2;
  localparam int REG_SIGMSK = 3;
  localparam int REG_COUNT  = 4;

  function automatic int flag_index(input int cls, input int bank, input int nbank);
    return cls * nbank + bank;
  endfunction

endpackage

// File: rtl/ecc_evt_gather.sv
module ecc_evt_gather
  import ecc_err_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int NFLAG = NCLASS * NBANK
) (
  input  logic [NBANK-1:0] ev_single,
  input  logic [NBANK-1:0] ev_multi,
  input  logic [NBANK-1:0] ev_strobe,
  input  logic [NBANK-1:0] ev_access,
  output logic [NFLAG-1:0] evt_vec
);

  logic [NBANK-1:0] per_class [NCLASS];

  assign per_class[CLS_SINGLE] = ev_single;
  assign per_class[CLS_MULTI]  = ev_multi;
  assign per_class[CLS_STROBE] = ev_strobe;
  assign per_class[CLS_ACCESS] = ev_access;

  for (genvar c = 0; c < NCLASS; c++) begin : g_cls
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign evt_vec[flag_index(c, b, NBANK)] = per_class[c][b];
    end
  end

endmodule

// File: rtl/ecc_reg_port.sv
module ecc_reg_port
  import ecc_err_pkg::*;
#(
  parameter int NFLAG  = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NFLAG-1:0]  flags,
  output logic              ecc_en,
  output logic [NFLAG-1:0]  rec_msk,
  output logic [NFLAG-1:0]  sig_msk,
  output logic [NFLAG-1:0]  flag_clr,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int PAD_W = DATA_W - NFLAG;

  logic [REG_COUNT-1:0] sel;
  logic                 unused_hi;

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_sel
    assign sel[r] = (bus_addr == ADDR_W'(r));
  end

  assign unused_hi = ^bus_wdata[DATA_W-1:NFLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecc_en  <= 1'b0;
      rec_msk <= '0;
      sig_msk <= '0;
    end else if (bus_we) begin
      if (sel[REG_CTRL])   ecc_en  <= bus_wdata[0];
      if (sel[REG_RECMSK]) rec_msk <= bus_wdata[NFLAG-1:0];
      if (sel[REG_SIGMSK]) sig_msk <= bus_wdata[NFLAG-1:0];
    end
  end

  assign flag_clr = (bus_we && sel[REG_FLAGS]) ? bus_wdata[NFLAG-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel[REG_CTRL]:   bus_rdata = {{(DATA_W-1){1'b0}}, ecc_en};
      sel[REG_FLAGS]:  bus_rdata = {{PAD_W{1'b0}}, flags};
      sel[REG_RECMSK]: bus_rdata = {{PAD_W{1'b0}}, rec_msk};
      sel[REG_SIGMSK]: bus_rdata = {{PAD_W{1'b0}}, sig_msk};
      default:         bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ecc_flag_bank.sv
module ecc_flag_bank #(
  parameter int NFLAG = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ecc_en,
  input  logic [NFLAG-1:0] evt_vec,
  input  logic [NFLAG-1:0] rec_msk,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [NFLAG-1:0] flags
);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic arm;
    assign arm = ecc_en & rec_msk[i] & evt_vec[i];
    always_ff @(posedge clk) begin
      if (!rst_n)           flags[i] <= 1'b0;
      else if (arm)         flags[i] <= 1'b1;
      else if (flag_clr[i]) flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/ecc_irq_gen.sv
module ecc_irq_gen #(
  parameter int NFLAG = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] sig_msk,
  output logic             irq
);

  logic pending;
  assign pending = |(flags & sig_msk);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pending;
  end

endmodule

// File: rtl/ecc_err_ctrl.sv
module ecc_err_ctrl
  import ecc_err_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  localparam int NFLAG = NCLASS * NBANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBANK-1:0]  ev_single,
  input  logic [NBANK-1:0]  ev_multi,
  input  logic [NBANK-1:0]  ev_strobe,
  input  logic [NBANK-1:0]  ev_access,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic [NFLAG-1:0] evt_vec;
  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] rec_msk_q;
  logic [NFLAG-1:0] sig_msk_q;
  logic [NFLAG-1:0] flag_clr;
  logic             ecc_en_q;

  ecc_evt_gather #(.NBANK(NBANK)) gather_i (
    .ev_single (ev_single),
    .ev_multi  (ev_multi),
    .ev_strobe (ev_strobe),
    .ev_access (ev_access),
    .evt_vec   (evt_vec)
  );

  ecc_reg_port #(.NFLAG(NFLAG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flags     (flags_q),
    .ecc_en    (ecc_en_q),
    .rec_msk   (rec_msk_q),
    .sig_msk   (sig_msk_q),
    .flag_clr  (flag_clr),
    .bus_rdata (bus_rdata)
  );

  ecc_flag_bank #(.NFLAG(NFLAG)) flags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ecc_en   (ecc_en_q),
    .evt_vec  (evt_vec),
    .rec_msk  (rec_msk_q),
    .flag_clr (flag_clr),
    .flags    (flags_q)
  );

  ecc_irq_gen #(.NFLAG(NFLAG)) irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags_q),
    .sig_msk (sig_msk_q),
    .irq     (irq)
  );

endmodule

// File: rtl/ecc_err_ctrl_chk.sv
module ecc_err_ctrl_chk #(
  parameter int NFLAG  = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NFLAG-1:0]  evt_vec,
  input logic [NFLAG-1:0]  flags_q,
  input logic [NFLAG-1:0]  rec_msk_q,
  input logic [NFLAG-1:0]  sig_msk_q,
  input logic [NFLAG-1:0]  flag_clr,
  input logic              ecc_en_q,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq
);

  a_r3_masked_event_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(rec_msk_q)) == '0));

  a_r4_off_records_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_en_q |=> ((flags_q & ~$past(flags_q)) == '0));

  a_r5_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr != '0) |=>
      ((flags_q & $past(flag_clr & ~(evt_vec & rec_msk_q & {NFLAG{ecc_en_q}}))) == '0));

  a_r6_event_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=>
      (($past(evt_vec & rec_msk_q & {NFLAG{ecc_en_q}}) & ~flags_q) == '0));

  a_r7_irq_one_late: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |$past(flags_q & sig_msk_q)));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(3)) |-> (bus_rdata == '0));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (bus_rdata[DATA_W-1:NFLAG] == '0));

endmodule

bind ecc_err_ctrl ecc_err_ctrl_chk #(.NFLAG(NFLAG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_vec   (evt_vec),
  .flags_q   (flags_q),
  .rec_msk_q (rec_msk_q),
  .sig_msk_q (sig_msk_q),
  .flag_clr  (flag_clr),
  .ecc_en_q  (ecc_en_q),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq)
);

// File: tb/ecc_err_ctrl_tb_top.sv
`timescale 1ns/1ps
module ecc_err_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ev_single = '0, ev_multi = '0, ev_strobe = '0, ev_access = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ecc_err_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_single(ev_single), .ev_multi(ev_multi),
    .ev_strobe(ev_strobe), .ev_access(ev_access),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Reference model, behavioural
  bit        m_en;
  bit [15:0] m_flags, m_rec, m_sig;
  bit        m_irq;

  function automatic bit ev_bit(int cls, int bank);
    case (cls)
      0: return ev_single[bank];
      1: return ev_multi[bank];
      2: return ev_strobe[bank];
      default: return ev_access[bank];
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_en};
      3'd1: return {16'd0, m_flags};
      3'd2: return {16'd0, m_rec};
      3'd3: return {16'd0, m_sig};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_flags = 0; m_rec = 0; m_sig = 0; m_irq = 0;
    end else begin
      bit [15:0] nxt;
      bit any;
      any = 0;
      for (int k = 0; k < 16; k++) if (m_flags[k] && m_sig[k]) any = 1;
      nxt = m_flags;
      for (int c = 0; c < 4; c++) begin
        for (int b = 0; b < 4; b++) begin
          int idx;
          idx = c * 4 + b;
          if (bus_we && bus_addr == 3'd1 && bus_wdata[idx]) nxt[idx] = 0;
          if (m_en && m_rec[idx] && ev_bit(c, b)) nxt[idx] = 1;
        end
      end
      if (bus_we) begin
        if (bus_addr == 3'd0) m_en = bus_wdata[0];
        if (bus_addr == 3'd2) m_rec = bus_wdata[15:0];
        if (bus_addr == 3'd3) m_sig = bus_wdata[15:0];
      end
      m_flags = nxt;
      m_irq = any;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      check("R10 rdata vs model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic step(bit we, logic [2:0] a, logic [31:0] d,
                      logic [3:0] s, logic [3:0] m, logic [3:0] t, logic [3:0] x);
    @(posedge clk); #1;
    bus_we = we; bus_addr = a; bus_wdata = d;
    ev_single = s; ev_multi = m; ev_strobe = t; ev_access = x;
    @(posedge clk); #1;
    bus_we = 0; ev_single = 0; ev_multi = 0; ev_strobe = 0; ev_access = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    step(1, a, d, 0, 0, 0, 0);
  endtask

  task automatic pulse(logic [3:0] s, logic [3:0] m, logic [3:0] t, logic [3:0] x);
    step(0, bus_addr, 0, s, m, t, x);
  endtask

  task automatic rd_check(string tag, logic [2:0] a, logic [31:0] exp);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd_check("R1 ctrl", 3'd0, 32'h0);
    rd_check("R1 flags", 3'd1, 32'h0);
    rd_check("R1 recmsk", 3'd2, 32'h0);
    rd_check("R1 sigmsk", 3'd3, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);

    // R4 checking off: nothing recorded
    wr(3'd2, 32'h0000_FFFF);
    pulse(4'hF, 4'hF, 4'hF, 4'hF);
    rd_check("R4 off no record", 3'd1, 32'h0);

    // R3 record mask 0: nothing recorded
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h1);
    pulse(4'hF, 4'hF, 4'hF, 4'hF);
    rd_check("R3 masked no record", 3'd1, 32'h0);

    // R2 layout, R8 set without signal mask
    wr(3'd2, 32'h0000_FFFF);
    pulse(4'b0100, 4'b0001, 4'b0010, 4'b1000);
    rd_check("R2 layout", 3'd1, 32'h0000_8214);
    check("R8 no irq with sig mask 0", {31'd0, irq}, 32'h0);

    // R7 timing
    wr(3'd3, 32'h0000_8000);
    @(negedge clk);
    check("R7 irq still low one cycle", {31'd0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq high", {31'd0, irq}, 32'h1);
    wr(3'd1, 32'h0000_8000);
    @(negedge clk);
    check("R7 irq held one cycle", {31'd0, irq}, 32'h1);
    @(negedge clk);
    check("R7 irq drops", {31'd0, irq}, 32'h0);

    // R5 write-one-to-clear
    wr(3'd1, 32'h0000_0000);
    rd_check("R5 zero write keeps", 3'd1, 32'h0000_0214);
    wr(3'd1, 32'h0000_0010);
    rd_check("R5 single clear", 3'd1, 32'h0000_0204);
    wr(3'd1, 32'h0000_FFFF);
    rd_check("R5 clear all", 3'd1, 32'h0);

    // R6 collision: set wins
    pulse(4'b0100, 0, 0, 0);
    step(1, 3'd1, 32'h0000_0004, 4'b0100, 0, 0, 0);
    rd_check("R6 event wins over clear", 3'd1, 32'h0000_0004);
    wr(3'd1, 32'h0000_FFFF);

    // R9 upper bits, unmapped addresses
    wr(3'd2, 32'hFFFF_FFFF);
    rd_check("R9 upper bits zero", 3'd2, 32'h0000_FFFF);
    wr(3'd0, 32'hFFFF_FFFF);
    rd_check("R9 ctrl one bit", 3'd0, 32'h0000_0001);
    wr(3'd5, 32'hFFFF_FFFF);
    rd_check("R9 unmapped reads zero", 3'd5, 32'h0);
    rd_check("R9 unmapped write ignored", 3'd3, 32'h0000_8000);

    // R3 read-modify-write clear of one mask bit
    wr(3'd2, 32'h0000_FFFF & ~32'h0000_0010);
    pulse(0, 4'b0001, 4'b0001, 0);
    rd_check("R3 rmw mask clears only bit4", 3'd1, 32'h0000_0100);

    // R4 turning off keeps existing flags
    wr(3'd0, 32'h0);
    pulse(4'hF, 4'hF, 4'hF, 4'hF);
    rd_check("R4 flags kept while off", 3'd1, 32'h0000_0100);
    wr(3'd1, 32'h0000_FFFF);

    // random mix, compared every cycle by the model
    seed = 7;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      seed = seed * 1103515245 + 12345;
      r = seed;
      @(posedge clk); #1;
      ev_single = r[3:0]; ev_multi = r[7:4]; ev_strobe = r[11:8]; ev_access = r[15:12];
      bus_we = (r[18:16] == 3'd0) || (r[18:16] == 3'd1);
      bus_addr = r[22:20];
      bus_wdata = {r[7:0], r[31:24], r[15:0]} ^ {16'h0, r[31:16]};
      if (bus_addr == 3'd0) bus_wdata[0] = r[23] | r[19];
    end
    @(posedge clk); #1;
    bus_we = 0; ev_single = 0; ev_multi = 0; ev_strobe = 0; ev_access = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule